// File: doc/BRIEF.md
# Bus Termination Mode Controller

This block picks the termination mode for one end of a parallel SCSI bus segment. There are three modes: single-ended, low-voltage differential and high-power differential. Two comparator bits arrive already digitised and describe the level on the shared mode-sense line, which may not be synchronous to the clock. The block synchronises them and classifies the level. It then passes the result through a forgiving persistence filter that advances only on a slow tick enable. A new mode is adopted only after the sensed classification has out-voted disagreeing samples by a set margin.

The committed mode drives three one-hot status lines. It also drives the controls of the analog termination: the regulator enable, the regulator voltage select, grounding of the positive lines, the single-ended and differential network enables, and line high impedance. A separate output enables the sense-line driver. A detach input takes the terminator off the bus, while mode detection keeps running. A master input chooses which terminator at each bus end drives the sense line.

Top module: `scsi_mode_ctl`

## Requirements
- R1: The synchronised comparator pair {cmp_hi, cmp_lo} classifies the level as follows: 2'b00 is single-ended, 2'b01 is low-voltage differential and 2'b11 is high-power differential.
- R2: After reset the committed mode is high-power differential (st_hpd=1), with the persistence count cleared.
- R3: A differing mode is committed only on a tick. It takes TERM agreeing ticks with no disagreement (default 180, one tick per millisecond). After TERM-1 such ticks the old mode still holds, and clock cycles without a tick change nothing.
- R4: During a pending change, a tick whose class differs from the candidate lowers the count by one instead of clearing it. With TERM-1 agreeing ticks, one glitch tick and then one agreeing tick, the old mode still holds. One further agreeing tick commits the new mode.
- R5: A new candidate replaces a pending one only after the count has decayed back to zero.
- R6: Every transition between any two modes uses the same delay. A new change can start on the tick right after a commit.
- R7: The unused combination 2'b10 is ignored, and ticks that see it leave the count unchanged.
- R8: In single-ended mode while connected: reg_hi_sel=1, pos_gnd=1, se_net_en=1, lvd_net_en=0 and lines_hiz=0.
- R9: In low-voltage differential mode while connected: reg_hi_sel=0, lvd_net_en=1, se_net_en=0, pos_gnd=0 and lines_hiz=0. In high-power differential mode: reg_hi_sel=0, lines_hiz=1 and both network enables are 0.
- R10: With detach=1: reg_en=0, sense_drv_en=0, lines_hiz=1, pos_gnd=0 and both network enables are 0. Detection and the status outputs keep working.
- R11: sense_drv_en=1 exactly when detach=0 and master=1.
- R12: Exactly one of st_se, st_lvd and st_hpd is high at all times after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick | input | 1 | Slow enable that advances the persistence filter |
| cmp_lo | input | 1 | Sense level above the lower threshold |
| cmp_hi | input | 1 | Sense level above the upper threshold |
| detach | input | 1 | 1 takes the terminator off the bus |
| master | input | 1 | 1 lets this terminator drive the sense line |
| st_se | output | 1 | Status: single-ended mode |
| st_lvd | output | 1 | Status: low-voltage differential mode |
| st_hpd | output | 1 | Status: high-power differential mode |
| reg_en | output | 1 | Termination regulator on |
| reg_hi_sel | output | 1 | 1 selects the higher regulator voltage |
| pos_gnd | output | 1 | Positive lines switched to ground |
| lines_hiz | output | 1 | All termination lines high impedance |
| se_net_en | output | 1 | Single-ended network enabled |
| lvd_net_en | output | 1 | Differential network enabled |
| sense_drv_en | output | 1 | Sense-line driver enabled |

## Verification
Each mode is reached from a different starting mode through clean runs of exactly TERM-1 and then TERM ticks, which pins the delay to the tick. A run interrupted by one glitch tick separates a down-counting filter from one that restarts or ignores disagreement. A switch of target in mid-run separates deferred candidate replacement from immediate replacement. Runs interleaved with the unused code, idle stretches without ticks, and changes to detach and master show that detection continues while detached and that the control outputs follow the mode and the two strap inputs.

// File: rtl/scsi_mode_pkg.sv
package scsi_mode_pkg;
   typedef enum logic [1:0] {
      BM_SE  = 2'd0,
      BM_LVD = 2'd1,
      BM_HPD = 2'd2
   } bus_mode_e;

   typedef struct packed {
      logic      valid;
      bus_mode_e mode;
   } level_class_t;

   typedef struct packed {
      logic st_se;
      logic st_lvd;
      logic st_hpd;
      logic reg_en;
      logic reg_hi_sel;
      logic pos_gnd;
      logic lines_hiz;
      logic se_net_en;
      logic lvd_net_en;
      logic sense_drv_en;
   } term_ctl_t;

   localparam term_ctl_t CTL_RESET = '{st_se: 1'b0, st_lvd: 1'b0, st_hpd: 1'b1,
                                       reg_en: 1'b0, reg_hi_sel: 1'b0, pos_gnd: 1'b0,
                                       lines_hiz: 1'b1, se_net_en: 1'b0, lvd_net_en: 1'b0,
                                       sense_drv_en: 1'b0};
endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
   parameter int          WIDTH   = 2,
   parameter int          STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 0) begin : g_bad
         $error("bit_sync: STAGES must not be negative");
      end
      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else begin : g_chain
         logic [WIDTH-1:0] pipe [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
            end else begin
               pipe[0] <= d;
               for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
            end
         end
         assign q = pipe[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/mode_classify.sv
module mode_classify
   import scsi_mode_pkg::*;
(
   input  logic         above_lo,
   input  logic         above_hi,
   output level_class_t cls
);
   always_comb begin
      cls.valid = 1'b1;
      cls.mode  = BM_HPD;
      unique case ({above_hi, above_lo})
         2'b00:   cls.mode = BM_SE;
         2'b01:   cls.mode = BM_LVD;
         2'b11:   cls.mode = BM_HPD;
         default: cls.valid = 1'b0;
      endcase
   end
endmodule

// File: rtl/persist_filter.sv
module persist_filter
   import scsi_mode_pkg::*;
#(
   parameter int TERM = 180
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  level_class_t cls,
   output bus_mode_e    committed
);
   localparam int CNT_W = $clog2(TERM + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(TERM - 1);
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

   generate
      if (TERM < 2) begin : g_bad_term
         $error("persist_filter: TERM must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;
   bus_mode_e        cand;
   logic             step;

   assign step = tick & cls.valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt       <= '0;
         cand      <= BM_HPD;
         committed <= BM_HPD;
      end else if (step) begin
         if (cnt == '0) begin
            if (cls.mode != committed) begin
               cand <= cls.mode;
               cnt  <= ONE;
            end
         end else if (cls.mode == cand) begin
            if (cnt == LAST) begin
               committed <= cand;
               cnt       <= '0;
            end else begin
               cnt <= cnt + ONE;
            end
         end else begin
            cnt <= cnt - ONE;
         end
      end
   end
endmodule

// File: rtl/term_ctl_decode.sv
module term_ctl_decode
   import scsi_mode_pkg::*;
#(
   parameter bit REG_OUTPUTS = 1'b0
) (
   input  logic      clk,
   input  logic      rst_n,
   input  bus_mode_e mode,
   input  logic      detach,
   input  logic      master,
   output term_ctl_t ctl
);
   term_ctl_t nxt;
   logic      attached;

   assign attached = ~detach;

   always_comb begin
      nxt.st_se        = (mode == BM_SE);
      nxt.st_lvd       = (mode == BM_LVD);
      nxt.st_hpd       = (mode == BM_HPD);
      nxt.reg_en       = attached;
      nxt.reg_hi_sel   = (mode == BM_SE);
      nxt.pos_gnd      = attached & (mode == BM_SE);
      nxt.lines_hiz    = detach | (mode == BM_HPD);
      nxt.se_net_en    = attached & (mode == BM_SE);
      nxt.lvd_net_en   = attached & (mode == BM_LVD);
      nxt.sense_drv_en = attached & master;
   end

   generate
      if (REG_OUTPUTS) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ctl <= CTL_RESET;
            else        ctl <= nxt;
         end
      end else begin : g_comb
         assign ctl = nxt;
      end
   endgenerate
endmodule

// File: rtl/scsi_mode_ctl.sv
module scsi_mode_ctl
   import scsi_mode_pkg::*;
#(
   parameter int TERM        = 180,
   parameter int SYNC_STAGES = 2,
   parameter bit REG_OUTPUTS = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic cmp_lo,
   input  logic cmp_hi,
   input  logic detach,
   input  logic master,
   output logic st_se,
   output logic st_lvd,
   output logic st_hpd,
   output logic reg_en,
   output logic reg_hi_sel,
   output logic pos_gnd,
   output logic lines_hiz,
   output logic se_net_en,
   output logic lvd_net_en,
   output logic sense_drv_en
);
   logic [1:0]   lvl_s;
   level_class_t cls;
   bus_mode_e    mode_q;
   term_ctl_t    ctl;

   bit_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({cmp_hi, cmp_lo}), .q(lvl_s)
   );

   mode_classify u_cls (
      .above_lo(lvl_s[0]), .above_hi(lvl_s[1]), .cls(cls)
   );

   persist_filter #(.TERM(TERM)) u_filt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .cls(cls), .committed(mode_q)
   );

   term_ctl_decode #(.REG_OUTPUTS(REG_OUTPUTS)) u_dec (
      .clk(clk), .rst_n(rst_n), .mode(mode_q), .detach(detach),
      .master(master), .ctl(ctl)
   );

   assign st_se        = ctl.st_se;
   assign st_lvd       = ctl.st_lvd;
   assign st_hpd       = ctl.st_hpd;
   assign reg_en       = ctl.reg_en;
   assign reg_hi_sel   = ctl.reg_hi_sel;
   assign pos_gnd      = ctl.pos_gnd;
   assign lines_hiz    = ctl.lines_hiz;
   assign se_net_en    = ctl.se_net_en;
   assign lvd_net_en   = ctl.lvd_net_en;
   assign sense_drv_en = ctl.sense_drv_en;
endmodule

// File: rtl/scsi_mode_ctl_chk.sv
module scsi_mode_ctl_chk (
   input logic clk,
   input logic rst_n,
   input logic tick,
   input logic detach,
   input logic master,
   input logic st_se,
   input logic st_lvd,
   input logic st_hpd,
   input logic reg_en,
   input logic reg_hi_sel,
   input logic pos_gnd,
   input logic lines_hiz,
   input logic se_net_en,
   input logic lvd_net_en,
   input logic sense_drv_en
);
   // R12
   status_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({st_se, st_lvd, st_hpd}) == 1);

   // R2
   reset_hpd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> st_hpd);

   // R3
   commit_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable({st_se, st_lvd, st_hpd}) |-> $past(tick));

   // R8
   se_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_se && !detach) |-> (pos_gnd && reg_hi_sel && se_net_en && !lines_hiz));

   // R9
   hpd_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st_hpd |-> (lines_hiz && !reg_hi_sel && !se_net_en && !lvd_net_en));

   // R10
   detach_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      detach |-> (lines_hiz && !reg_en && !sense_drv_en && !pos_gnd));

   // R11
   driver_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!detach && master) |-> sense_drv_en);
endmodule

bind scsi_mode_ctl scsi_mode_ctl_chk u_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick), .detach(detach), .master(master),
   .st_se(st_se), .st_lvd(st_lvd), .st_hpd(st_hpd), .reg_en(reg_en),
   .reg_hi_sel(reg_hi_sel), .pos_gnd(pos_gnd), .lines_hiz(lines_hiz),
   .se_net_en(se_net_en), .lvd_net_en(lvd_net_en), .sense_drv_en(sense_drv_en)
);

// File: tb/scsi_mode_ctl_tb.sv
module scsi_mode_ctl_tb;
   localparam int T = 16;
   localparam int M_SE = 0, M_LVD = 1, M_HPD = 2;

   logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
   logic cmp_lo = 1'b1, cmp_hi = 1'b1, detach = 1'b0, master = 1'b1;
   logic st_se, st_lvd, st_hpd, reg_en, reg_hi_sel, pos_gnd, lines_hiz;
   logic se_net_en, lvd_net_en, sense_drv_en;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   typedef struct { string req; logic [9:0] exp; } item_t;
   item_t sb_q[$];

   always #10 clk = ~clk;

   scsi_mode_ctl #(.TERM(T)) u_dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .cmp_lo(cmp_lo), .cmp_hi(cmp_hi),
      .detach(detach), .master(master), .st_se(st_se), .st_lvd(st_lvd),
      .st_hpd(st_hpd), .reg_en(reg_en), .reg_hi_sel(reg_hi_sel),
      .pos_gnd(pos_gnd), .lines_hiz(lines_hiz), .se_net_en(se_net_en),
      .lvd_net_en(lvd_net_en), .sense_drv_en(sense_drv_en)
   );

   function automatic logic [9:0] model(int m, logic det, logic mst);
      logic se, lv, hp;
      se = (m == M_SE); lv = (m == M_LVD); hp = (m == M_HPD);
      return {se, lv, hp, !det, se, !det && se, det || hp,
              !det && se, !det && lv, !det && mst};
   endfunction

   // driver side: push the expected output vector for the current state
   task automatic expect_mode(string req, int m);
      item_t it;
      it.req = req;
      it.exp = model(m, detach, master);
      sb_q.push_back(it);
      repeat (2) @(negedge clk);
   endtask

   task automatic set_lvl(logic hi, logic lo);
      cmp_hi = hi; cmp_lo = lo;
      repeat (3) @(negedge clk);
   endtask

   task automatic ticks(int n);
      for (int i = 0; i < n; i++) begin
         tick = 1'b1;
         @(negedge clk);
         tick = 1'b0;
         @(negedge clk);
      end
   endtask

   // monitor side: compare against the outputs away from the active edge
   always @(negedge clk) begin
      logic [9:0] act;
      item_t it;
      act = {st_se, st_lvd, st_hpd, reg_en, reg_hi_sel, pos_gnd, lines_hiz,
             se_net_en, lvd_net_en, sense_drv_en};
      while (sb_q.size() > 0) begin
         it = sb_q.pop_front();
         checks++;
         if (act !== it.exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", it.req, act, it.exp);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      expect_mode("R2 reset mode", M_HPD);

      // R1 R3 single-ended after exactly T ticks
      set_lvl(1'b0, 1'b0);
      ticks(T - 1);
      expect_mode("R3 not yet at T-1", M_HPD);
      ticks(1);
      expect_mode("R1 R3 R8 commit single-ended", M_SE);

      // R4 glitch decrements instead of restarting
      set_lvl(1'b0, 1'b1);
      ticks(T - 1);
      set_lvl(1'b0, 1'b0);
      ticks(1);
      set_lvl(1'b0, 1'b1);
      ticks(1);
      expect_mode("R4 glitch costs two ticks", M_SE);
      ticks(1);
      expect_mode("R4 R1 R9 commit differential", M_LVD);

      // R6 R7 immediate restart, invalid code ignored
      set_lvl(1'b1, 1'b1);
      ticks(T - 2);
      set_lvl(1'b1, 1'b0);
      ticks(5);
      set_lvl(1'b1, 1'b1);
      ticks(1);
      expect_mode("R7 invalid code left count alone", M_LVD);
      ticks(1);
      expect_mode("R6 R9 commit high-power", M_HPD);

      // R5 candidate replaced only after decay
      set_lvl(1'b0, 1'b0);
      ticks(3);
      set_lvl(1'b0, 1'b1);
      ticks(3 + T - 1);
      expect_mode("R5 old candidate decayed first", M_HPD);
      ticks(1);
      expect_mode("R5 new candidate committed", M_LVD);

      // R3 no tick, no progress
      set_lvl(1'b0, 1'b0);
      repeat (3 * T) @(negedge clk);
      expect_mode("R3 idle without tick", M_LVD);

      // R10 detached, detection continues
      detach = 1'b1;
      repeat (2) @(negedge clk);
      expect_mode("R10 detach outputs", M_LVD);
      ticks(T);
      expect_mode("R10 detection while detached", M_SE);
      detach = 1'b0;
      repeat (2) @(negedge clk);
      expect_mode("R8 R12 reattached single-ended", M_SE);

      // R11 master strap
      master = 1'b0;
      repeat (2) @(negedge clk);
      expect_mode("R11 slave driver off", M_SE);
      master = 1'b1;
      detach = 1'b1;
      repeat (2) @(negedge clk);
      expect_mode("R11 detached driver off", M_SE);
      detach = 1'b0;
      repeat (2) @(negedge clk);
      expect_mode("R11 master driver on", M_SE);

      repeat (4) @(negedge clk);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule